// File: doc/BRIEF.md
# Coherence Directory Home Controller

This block is the home node of a small shared memory that several caching agents use at once. For every line it holds one data word and one directory entry. The entry records whether the line is uncached, held read-only by a set of agents, or held writable by a single owner. Request messages arrive on one input port and carry a type, a source id, an address and data. The block answers on one output port one cycle later with a grant, a negative acknowledge, an invalidation or a recall.

Sometimes a request conflicts with the directory. Two cases apply: a read-shared request to a line held writable by another agent, or a read-exclusive request to a line that other agents share. The controller then opens its single pending transaction slot. It recalls the owner's copy, or it invalidates the sharers and counts their acknowledgements. Only after that does it grant the requester. The network may deliver messages in any order, so a writeback can overtake a recall reply. The controller accepts the writeback as the recalled data and drops the recall reply that arrives later.

The output destination is an agent mask. Grants, recalls and negative acknowledges are one-hot. An invalidation is a single multicast message whose mask names every sharer to invalidate.

Top module: `coh_home`

## Requirements
- R1: After reset every line is uncached with data zero and no reply is presented. A first read-shared request to any line is granted with data 0.
- R2: A read-shared request (type 0) to an uncached or shared line replies with grant-shared (type 0) to the requester, carrying the memory word, and adds the requester to the sharer set.
- R3: A read-exclusive request (type 1) to an uncached line, or to a shared line whose only sharer is the requester, replies at once with grant-exclusive (type 1) carrying the memory word. The requester becomes the sole owner.
- R4: A read-exclusive request to a shared line with other sharers emits one invalidate (type 3) whose mask is the sharer set without the requester. Invalidation acknowledgements (type 3) before the last one produce no reply. The last one produces grant-exclusive to the requester.
- R5: A read-shared request to a line owned by another agent emits a recall (type 4) to the owner. The owner's recall reply (type 4) writes its data to memory and yields grant-shared with that data to the requester.
- R6: A read-exclusive request to a line owned by another agent recalls the owner. The recall reply yields grant-exclusive with the returned data to the requester.
- R7: A writeback (type 2) from the owner writes memory and makes the line uncached, with no reply.
- R8: A writeback from the recalled owner that arrives before its recall reply completes the pending grant with the writeback data. The later recall reply is dropped with no reply, and memory keeps the writeback data.
- R9: A negative acknowledge (type 2) answers these requests: a request to a line with a pending transaction, a read request from the line's current owner, and a conflicting request while the slot serves another line.
- R10: A writeback from an agent that is not the owner, and an acknowledgement with no matching pending invalidation, produce no reply and leave memory unchanged.
- R11: A writable line always has an empty sharer set, and a shared line a non-empty one. Grants, recalls and negative acknowledges address exactly one agent.
- R12: Requests to other lines that need no new transaction are served normally while a transaction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request message present |
| req_type | input | 3 | 0 read-shared, 1 read-exclusive, 2 writeback, 3 invalidate ack, 4 recall reply |
| req_src | input | ID_W | sending agent id |
| req_addr | input | ADDR_W | line address |
| req_data | input | DATA_W | data of writeback or recall reply |
| rsp_valid | output | 1 | reply message present |
| rsp_type | output | 3 | 0 grant-shared, 1 grant-exclusive, 2 nack, 3 invalidate, 4 recall |
| rsp_dst | output | AGENTS | destination agent mask |
| rsp_addr | output | ADDR_W | line address |
| rsp_data | output | DATA_W | grant data |

## Verification
Two things can fall in the same cycle. One line's transaction can complete, through its last acknowledgement, a recall reply or an early writeback, while a request to another line is refused because the slot is taken. Or a line can be served normally while another line waits on a recall. The bench provokes both by sending conflicting and independent traffic to other lines while recalls and invalidations are outstanding. It judges each reply against a per-line model of state, sharers, owner and data kept in the bench. A randomized phase then reorders writebacks, recalls and acknowledgement sequences on two lines.

// File: rtl/coh_home.sv
module coh_home #(
  parameter int AGENTS = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int ID_W  = $clog2(AGENTS),
  localparam int LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ID_W-1:0]   req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_type,
  output logic [AGENTS-1:0] rsp_dst,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [1:0] S_INV = 2'd0, S_SHR = 2'd1, S_EXC = 2'd2;
  localparam logic [2:0] M_RSH = 3'd0, M_REX = 3'd1, M_WB = 3'd2, M_ACK = 3'd3, M_RCR = 3'd4;
  localparam logic [2:0] O_GSH = 3'd0, O_GEX = 3'd1, O_NAK = 3'd2, O_INV = 3'd3, O_RCL = 3'd4;
  localparam logic [1:0] K_RSH = 2'd0, K_REX = 2'd1, K_INV = 2'd2;

  logic [1:0]        dir_st [LINES];
  logic [AGENTS-1:0] shr    [LINES];
  logic [ID_W-1:0]   own    [LINES];
  logic [DATA_W-1:0] mem    [LINES];

  logic              p_on, p_drain;
  logic [1:0]        p_kind;
  logic [ADDR_W-1:0] p_addr;
  logic [ID_W-1:0]   p_req, p_tgt;
  logic [ID_W:0]     p_cnt;

  wire [1:0]        st     = dir_st[req_addr];
  wire [ID_W-1:0]   own_a  = own[req_addr];
  wire [AGENTS-1:0] src_b  = AGENTS'(1) << req_src;
  wire [AGENTS-1:0] others = shr[req_addr] & ~src_b;
  wire              hit    = p_on && p_addr == req_addr;
  wire              is_own = st == S_EXC && own_a == req_src;

  wire fin_wb  = req_valid && req_type == M_WB && is_own && hit && !p_drain && p_kind != K_INV;
  wire fin_rc  = req_valid && req_type == M_RCR && hit && !p_drain && p_kind != K_INV && req_src == p_tgt;
  wire fin_ack = req_valid && req_type == M_ACK && hit && !p_drain && p_kind == K_INV && p_cnt == 1;
  wire do_fin  = fin_wb || fin_rc || fin_ack;
  wire [DATA_W-1:0] fin_data = fin_ack ? mem[p_addr] : req_data;

  task automatic reply(input logic [2:0] t, input logic [AGENTS-1:0] d, input logic [DATA_W-1:0] v);
    rsp_valid <= 1'b1;
    rsp_type  <= t;
    rsp_dst   <= d;
    rsp_addr  <= req_addr;
    rsp_data  <= v;
  endtask

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        dir_st[i] <= S_INV;
        shr[i]    <= '0;
        own[i]    <= '0;
        mem[i]    <= '0;
      end
      p_on <= 1'b0; p_drain <= 1'b0; p_kind <= K_RSH;
      p_addr <= '0; p_req <= '0; p_tgt <= '0; p_cnt <= '0;
      rsp_valid <= 1'b0; rsp_type <= '0; rsp_dst <= '0; rsp_addr <= '0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid) begin
        case (req_type)
          M_RSH, M_REX: begin
            if (hit || is_own || (p_on && (st == S_EXC || (req_type == M_REX && st == S_SHR && others != 0))))
              reply(O_NAK, src_b, '0);
            else if (st == S_EXC) begin
              reply(O_RCL, AGENTS'(1) << own_a, '0);
              p_on <= 1'b1; p_addr <= req_addr; p_req <= req_src; p_tgt <= own_a;
              p_kind <= (req_type == M_RSH) ? K_RSH : K_REX;
            end else if (req_type == M_RSH) begin
              dir_st[req_addr] <= S_SHR;
              shr[req_addr]    <= shr[req_addr] | src_b;
              reply(O_GSH, src_b, mem[req_addr]);
            end else if (st == S_SHR && others != 0) begin
              reply(O_INV, others, '0);
              p_on <= 1'b1; p_addr <= req_addr; p_req <= req_src; p_kind <= K_INV;
              p_cnt <= (ID_W+1)'($countones(others));
            end else begin
              dir_st[req_addr] <= S_EXC;
              shr[req_addr]    <= '0;
              own[req_addr]    <= req_src;
              reply(O_GEX, src_b, mem[req_addr]);
            end
          end
          M_WB: if (is_own) begin
            mem[req_addr] <= req_data;
            if (fin_wb) p_drain <= 1'b1;
            else dir_st[req_addr] <= S_INV;
          end
          M_ACK: if (hit && !p_drain && p_kind == K_INV) begin
            p_cnt <= p_cnt - 1'b1;
            if (fin_ack) p_on <= 1'b0;
          end
          M_RCR: if (hit && p_kind != K_INV && req_src == p_tgt) begin
            p_on <= 1'b0; p_drain <= 1'b0;
            if (!p_drain) mem[req_addr] <= req_data;
          end
          default: ;
        endcase
      end
      if (do_fin) begin
        rsp_valid <= 1'b1;
        rsp_dst   <= AGENTS'(1) << p_req;
        rsp_addr  <= p_addr;
        rsp_data  <= fin_data;
        shr[p_addr] <= (p_kind == K_RSH) ? AGENTS'(1) << p_req : '0;
        if (p_kind == K_RSH) begin
          dir_st[p_addr] <= S_SHR;
          rsp_type <= O_GSH;
        end else begin
          dir_st[p_addr] <= S_EXC;
          own[p_addr]    <= p_req;
          rsp_type <= O_GEX;
        end
      end
    end
  end

  a_r11_single_dst: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_type != O_INV |-> $onehot(rsp_dst));
  a_r4_inval_not_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_type == O_INV |-> rsp_dst != 0 && !rsp_dst[p_req]);
  a_r4_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    p_on && !p_drain && p_kind == K_INV |-> p_cnt != 0);
  a_r2_reply_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  for (genvar g = 0; g < LINES; g++) begin : g_inv
    a_r11_excl_no_sharer: assert property (@(posedge clk) disable iff (!rst_n)
      dir_st[g] == S_EXC |-> shr[g] == 0);
    a_r11_shared_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      dir_st[g] == S_SHR |-> shr[g] != 0);
  end
endmodule

// File: tb/coh_home_tb_top.sv
`timescale 1ns/1ps
module coh_home_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_type = 0;
  logic [1:0] req_src = 0;
  logic [2:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic rsp_valid;
  logic [2:0] rsp_type;
  logic [3:0] rsp_dst;
  logic [2:0] rsp_addr;
  logic [7:0] rsp_data;
  int n_chk = 0, n_bad = 0;
  logic ov; logic [2:0] ot; logic [3:0] od; logic [7:0] odat;

  coh_home dut_i (.*);
  always #4 clk = ~clk;

  task automatic send(input logic [2:0] t, input int s, input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_type = t; req_src = 2'(s); req_addr = 3'(a); req_data = d;
    @(negedge clk);
    ov = rsp_valid; ot = rsp_type; od = rsp_dst; odat = rsp_data;
    req_valid = 0;
  endtask

  task automatic chk(input string tag, input bit ev, input logic [2:0] et,
                     input logic [3:0] ed, input logic [7:0] edat);
    bit bad;
    n_chk++;
    if (!ev) bad = ov;
    else bad = !ov || ot != et || od != ed || (et <= 1 && odat != edat);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v=%0d t=%0d d=%b data=%h exp v=%0d t=%0d d=%b data=%h",
               tag, ov, ot, od, odat, ev, et, ed, edat);
    end
  endtask

  function automatic logic [3:0] bitof(input int a); return 4'(1) << a; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [1:0] mst [2]; logic [3:0] msh [2]; int mown [2]; logic [7:0] mmem [2];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); ov = rsp_valid; chk("R1 idle after reset", 0, 0, 0, 0);
    send(0, 0, 0, 0); chk("R1 R2 first read", 1, 0, 4'b0001, 8'h00);
    send(0, 1, 0, 0); chk("R2 second sharer", 1, 0, 4'b0010, 8'h00);
    send(1, 2, 0, 0); chk("R4 inval multicast", 1, 3, 4'b0011, 0);
    send(0, 3, 0, 0); chk("R9 nack pending line", 1, 2, 4'b1000, 0);
    send(1, 3, 1, 0); chk("R12 R3 other line served", 1, 1, 4'b1000, 8'h00);
    send(3, 0, 0, 0); chk("R4 first ack silent", 0, 0, 0, 0);
    send(3, 1, 0, 0); chk("R4 last ack grants", 1, 1, 4'b0100, 8'h00);
    send(2, 2, 0, 8'h5A); chk("R7 writeback silent", 0, 0, 0, 0);
    send(0, 1, 0, 0); chk("R7 data after writeback", 1, 0, 4'b0010, 8'h5A);
    send(1, 1, 0, 0); chk("R3 sole sharer upgrade", 1, 1, 4'b0010, 8'h5A);
    send(0, 0, 0, 0); chk("R5 recall owner", 1, 4, 4'b0010, 0);
    send(4, 1, 0, 8'h33); chk("R5 grant shared after recall", 1, 0, 4'b0001, 8'h33);
    send(0, 2, 0, 0); chk("R5 memory updated", 1, 0, 4'b0100, 8'h33);
    send(1, 0, 2, 0); chk("R6 setup", 1, 1, 4'b0001, 8'h00);
    send(1, 3, 2, 0); chk("R6 recall", 1, 4, 4'b0001, 0);
    send(4, 0, 2, 8'h77); chk("R6 grant exclusive", 1, 1, 4'b1000, 8'h77);
    send(1, 1, 3, 0); chk("R8 setup", 1, 1, 4'b0010, 8'h00);
    send(0, 2, 3, 0); chk("R8 recall", 1, 4, 4'b0010, 0);
    send(2, 1, 3, 8'h44); chk("R8 writeback satisfies recall", 1, 0, 4'b0100, 8'h44);
    send(0, 0, 3, 0); chk("R9 nack while draining", 1, 2, 4'b0001, 0);
    send(4, 1, 3, 8'h99); chk("R8 stale reply dropped", 0, 0, 0, 0);
    send(0, 0, 3, 0); chk("R8 memory keeps writeback", 1, 0, 4'b0001, 8'h44);
    send(0, 3, 1, 0); chk("R9 nack owner read", 1, 2, 4'b1000, 0);
    send(0, 0, 1, 0); chk("R5 recall line1", 1, 4, 4'b1000, 0);
    send(0, 1, 2, 0); chk("R9 nack slot busy", 1, 2, 4'b0010, 0);
    send(0, 1, 5, 0); chk("R12 independent read", 1, 0, 4'b0010, 8'h00);
    send(4, 3, 1, 8'h12); chk("R5 line1 grant", 1, 0, 4'b0001, 8'h12);
    send(2, 2, 1, 8'hFF); chk("R10 foreign writeback silent", 0, 0, 0, 0);
    send(0, 2, 1, 0); chk("R10 memory unchanged", 1, 0, 4'b0100, 8'h12);
    send(3, 0, 6, 0); chk("R10 stray ack silent", 0, 0, 0, 0);

    for (int l = 0; l < 2; l++) begin mst[l] = 0; msh[l] = 0; mown[l] = 0; mmem[l] = 0; end
    void'($urandom(32'd1234));
    for (int it = 0; it < 300; it++) begin
      int l, a, b; logic [7:0] d; logic [3:0] oth;
      l = $urandom_range(1); a = $urandom_range(3); d = 8'($urandom);
      case (mst[l])
        0: begin
          send(1, a, 6 + l, 0); chk("R3 rand grant excl", 1, 1, bitof(a), mmem[l]);
          mst[l] = 2; mown[l] = a;
        end
        2: begin
          if ($urandom_range(1) == 0) begin
            send(2, mown[l], 6 + l, d); chk("R7 rand writeback", 0, 0, 0, 0);
            mmem[l] = d; mst[l] = 0;
          end else begin
            b = (mown[l] + 1 + $urandom_range(2)) % 4;
            send(0, b, 6 + l, 0); chk("R5 rand recall", 1, 4, bitof(mown[l]), 0);
            if ($urandom_range(1) == 0) begin
              send(4, mown[l], 6 + l, d); chk("R5 rand grant", 1, 0, bitof(b), d);
            end else begin
              send(2, mown[l], 6 + l, d); chk("R8 rand early wb", 1, 0, bitof(b), d);
              send(4, mown[l], 6 + l, ~d); chk("R8 rand stale drop", 0, 0, 0, 0);
            end
            mmem[l] = d; mst[l] = 1; msh[l] = bitof(b);
          end
        end
        default: begin
          if ($urandom_range(1) == 0) begin
            send(0, a, 6 + l, 0); chk("R2 rand read shared", 1, 0, bitof(a), mmem[l]);
            msh[l] |= bitof(a);
          end else begin
            oth = msh[l] & ~bitof(a);
            send(1, a, 6 + l, 0);
            if (oth == 0) chk("R3 rand upgrade", 1, 1, bitof(a), mmem[l]);
            else begin
              chk("R4 rand inval", 1, 3, oth, 0);
              for (int k = 3; k >= 0; k--) if (oth[k]) begin
                oth[k] = 0;
                send(3, k, 6 + l, 0);
                if (oth == 0) chk("R4 rand last ack", 1, 1, bitof(a), mmem[l]);
                else chk("R4 rand ack silent", 0, 0, 0, 0);
              end
            end
            mst[l] = 2; mown[l] = a; msh[l] = 0;
          end
        end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule